// File: doc/BRIEF.md
# SECDED Hamming Code Encoder

This block turns a K-bit information word into an extended Hamming code word that lets a downstream decoder correct any single flipped bit and detect any pair of flipped bits. It is pure combinational logic: the code word, the check-bit vector and the overall parity bit follow the data input within the same cycle. There is no clock, no register and no handshake.

The number of check bits is derived from the data width when the design is elaborated. The code word has three parts: a Hamming section of data and check bits interleaved, plus one overall parity bit. A parameter places that overall bit at the top or at the bottom of the word, so the word matches the layout the storage or link expects. The check-bit vector and the overall bit also come out on ports of their own. Callers that keep data and check bits in separate arrays can take them from there.

Top module: `secded_encoder`

## Requirements
- R1: The check-bit count CHK_W is the smallest m >= 1 with 2^m >= m + DATA_W + 1, and code_o is DATA_W + CHK_W + 1 bits wide (13, 22, 39 and 72 bits for DATA_W of 8, 16, 32 and 64).
- R2: Hamming positions are numbered 1 to DATA_W + CHK_W. Data bits fill the positions that are not powers of two, with data_i[0] at the lowest such position and the rest in ascending order.
- R3: Check bit i sits at Hamming position 2^i. It equals the XOR of all other positions whose index has bit i set, so the syndrome of an unaltered code word is zero.
- R4: The overall parity bit is the XOR of every other bit of the code word, so code_o always has an even number of ones.
- R5: With OVERALL_AT_LSB = 0, Hamming position p drives code_o[p-1] and the overall bit drives code_o[DATA_W+CHK_W].
- R6: With OVERALL_AT_LSB = 1, the overall bit drives code_o[0] and Hamming position p drives code_o[p].
- R7: parity_o[i] equals the check bit at Hamming position 2^i, and overall_o equals the overall bit in code_o.
- R8: An all-zero data word gives an all-zero code word, check-bit vector and overall bit.
- R9: All outputs follow a change on data_i with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W | Information word to protect |
| code_o | output | DATA_W+CHK_W+1 | Complete code word: Hamming section plus overall parity bit |
| parity_o | output | CHK_W | Hamming check bits, bit i from position 2^i |
| overall_o | output | 1 | Overall (extended) parity bit |

## Verification
The bound checker reads the code word back on every evaluation. It confirms that the data bits land at the non-power-of-two positions and that the rebuilt syndrome is zero. It also checks that the word has even parity, and that the separate check-bit and overall ports agree with the bits embedded in the word. The bench does things the checker cannot. It confirms the derived widths for each supported data width. It compares every output against an independently built code word for all 256 inputs of the 8-bit configuration, in both placements of the overall bit. It sweeps walking-one and pseudo-random patterns across the wider configurations and shows that outputs settle without any clock edge.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // smallest m with 2^m >= m + k + 1
  function automatic int chk_bits(int k);
    int m;
    m = 1;
    while ((1 << m) < (m + k + 1)) m++;
    return m;
  endfunction

  function automatic bit is_pow2(int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // floor(log2(v)) for v >= 1
  function automatic int flog2(int v);
    int r;
    r = 0;
    while ((v >> (r + 1)) != 0) r++;
    return r;
  endfunction

  // data bit index held at a non-power-of-two Hamming position
  function automatic int data_index(int pos);
    return pos - flog2(pos) - 2;
  endfunction

endpackage

// File: rtl/secded_scatter.sv
module secded_scatter
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HAM_W  = 12
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W:1]    ham_o
);

  // place data bits into the non-power-of-two positions, check slots zero
  for (genvar pos = 1; pos <= HAM_W; pos++) begin : g_pos
    if (is_pow2(pos)) begin : g_slot
      assign ham_o[pos] = 1'b0;
    end else begin : g_data
      assign ham_o[pos] = data_i[data_index(pos)];
    end
  end

endmodule

// File: rtl/secded_checkgen.sv
module secded_checkgen #(
  parameter int HAM_W = 12,
  parameter int CHK_W = 4
) (
  input  logic [HAM_W:1]   ham_i,
  output logic [CHK_W-1:0] chk_o
);

  // check bit i covers every position whose index has bit i set
  for (genvar i = 0; i < CHK_W; i++) begin : g_chk
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int pos = 1; pos <= HAM_W; pos++) begin
        if (((pos >> i) & 1) == 1) acc = acc ^ ham_i[pos];
      end
      chk_o[i] = acc;
    end
  end

endmodule

// File: rtl/secded_assemble.sv
module secded_assemble
  import secded_pkg::*;
#(
  parameter int HAM_W          = 12,
  parameter int CHK_W          = 4,
  parameter bit OVERALL_AT_LSB = 1'b0
) (
  input  logic [HAM_W:1]   ham_i,
  input  logic [CHK_W-1:0] chk_i,
  output logic [HAM_W:0]   code_o,
  output logic             overall_o
);

  logic [HAM_W:1] chk_spread;
  logic [HAM_W:1] ham_full;

  for (genvar pos = 1; pos <= HAM_W; pos++) begin : g_spread
    if (is_pow2(pos)) begin : g_chk
      assign chk_spread[pos] = chk_i[flog2(pos)];
    end else begin : g_gap
      assign chk_spread[pos] = 1'b0;
    end
  end

  // check slots in ham_i are zero, so OR merges the two halves
  assign ham_full  = ham_i | chk_spread;
  assign overall_o = ^ham_full;

  if (OVERALL_AT_LSB) begin : g_lsb
    assign code_o = {ham_full, overall_o};
  end else begin : g_msb
    assign code_o = {overall_o, ham_full};
  end

endmodule

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter bit OVERALL_AT_LSB = 1'b0,
  localparam int CHK_W         = chk_bits(DATA_W),
  localparam int HAM_W         = DATA_W + CHK_W,
  localparam int CODE_W        = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CHK_W-1:0]  parity_o,
  output logic              overall_o
);

  logic [HAM_W:1] ham_data;

  secded_scatter #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_scatter (
    .data_i (data_i),
    .ham_o  (ham_data)
  );

  secded_checkgen #(.HAM_W(HAM_W), .CHK_W(CHK_W)) u_checkgen (
    .ham_i (ham_data),
    .chk_o (parity_o)
  );

  secded_assemble #(
    .HAM_W(HAM_W), .CHK_W(CHK_W), .OVERALL_AT_LSB(OVERALL_AT_LSB)
  ) u_assemble (
    .ham_i     (ham_data),
    .chk_i     (parity_o),
    .code_o    (code_o),
    .overall_o (overall_o)
  );

endmodule

// File: rtl/secded_encoder_chk.sv
module secded_encoder_chk
  import secded_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter bit OVERALL_AT_LSB = 1'b0,
  localparam int CHK_W         = chk_bits(DATA_W),
  localparam int HAM_W         = DATA_W + CHK_W,
  localparam int CODE_W        = HAM_W + 1
) (
  input logic [DATA_W-1:0] data_i,
  input logic [CODE_W-1:0] code_o,
  input logic [CHK_W-1:0]  parity_o,
  input logic              overall_o
);

  logic [HAM_W:1]    ham_seen;
  logic              ovr_seen;
  logic [DATA_W-1:0] data_seen;
  logic [CHK_W-1:0]  chk_seen;
  logic [CHK_W-1:0]  syndrome;

  // R5 / R6: read the Hamming section and overall bit back out of the word
  if (OVERALL_AT_LSB) begin : g_lsb
    assign ham_seen = code_o[HAM_W:1];
    assign ovr_seen = code_o[0];
  end else begin : g_msb
    assign ham_seen = code_o[HAM_W-1:0];
    assign ovr_seen = code_o[HAM_W];
  end

  for (genvar pos = 1; pos <= HAM_W; pos++) begin : g_rd
    if (is_pow2(pos)) begin : g_c
      assign chk_seen[flog2(pos)] = ham_seen[pos];
    end else begin : g_d
      assign data_seen[data_index(pos)] = ham_seen[pos];
    end
  end

  always_comb begin
    syndrome = '0;
    for (int pos = 1; pos <= HAM_W; pos++) begin
      if (ham_seen[pos]) syndrome = syndrome ^ CHK_W'(pos);
    end
  end

  always_comb begin
    p_data_place_r2: assert (data_seen == data_i)
      else $error("data bits misplaced in code word");
    p_zero_syndrome_r3: assert (syndrome == '0)
      else $error("nonzero syndrome on fresh code word");
    p_even_word_r4: assert (^code_o == 1'b0)
      else $error("code word parity is odd");
    p_parity_port_r7: assert (parity_o == chk_seen)
      else $error("parity port disagrees with code word");
    p_overall_port_r7: assert (overall_o == ovr_seen)
      else $error("overall port disagrees with code word");
    p_zero_in_r8: assert (data_i != '0 || code_o == '0)
      else $error("zero data gave nonzero code word");
  end

endmodule

bind secded_encoder secded_encoder_chk #(
  .DATA_W(DATA_W), .OVERALL_AT_LSB(OVERALL_AT_LSB)
) u_chk (
  .data_i    (data_i),
  .code_o    (code_o),
  .parity_o  (parity_o),
  .overall_o (overall_o)
);

// File: tb/secded_encoder_bench.sv
module secded_encoder_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [7:0]  d8;
  logic [15:0] d16;
  logic [31:0] d32;
  logic [63:0] d64;

  logic [12:0] c8m, c8l;
  logic [3:0]  p8m, p8l;
  logic        o8m, o8l;
  logic [21:0] c16;
  logic [4:0]  p16;
  logic        o16;
  logic [38:0] c32;
  logic [5:0]  p32;
  logic        o32;
  logic [71:0] c64;
  logic [6:0]  p64;
  logic        o64;

  secded_encoder #(.DATA_W(8), .OVERALL_AT_LSB(1'b0)) u_secded_encoder (
    .data_i(d8), .code_o(c8m), .parity_o(p8m), .overall_o(o8m));
  secded_encoder #(.DATA_W(8), .OVERALL_AT_LSB(1'b1)) u_secded_encoder_lsb (
    .data_i(d8), .code_o(c8l), .parity_o(p8l), .overall_o(o8l));
  secded_encoder #(.DATA_W(16), .OVERALL_AT_LSB(1'b1)) u_secded_encoder_w16 (
    .data_i(d16), .code_o(c16), .parity_o(p16), .overall_o(o16));
  secded_encoder #(.DATA_W(32), .OVERALL_AT_LSB(1'b0)) u_secded_encoder_w32 (
    .data_i(d32), .code_o(c32), .parity_o(p32), .overall_o(o32));
  secded_encoder #(.DATA_W(64), .OVERALL_AT_LSB(1'b0)) u_secded_encoder_w64 (
    .data_i(d64), .code_o(c64), .parity_o(p64), .overall_o(o64));

  task automatic check(bit ok, string req, logic [71:0] act, logic [71:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected code word built from the position rules
  task automatic verify(int k, bit lsb, logic [63:0] d, logic [71:0] code,
                        logic [6:0] par, logic ov);
    int m;
    int di;
    logic [72:0] ham;
    logic [71:0] exp_code;
    logic [6:0]  exp_par;
    logic        exp_ov;
    logic        p;
    m = 1;
    while ((1 << m) < (m + k + 1)) m++;
    ham = '0;
    di  = 0;
    for (int pos = 1; pos <= k + m; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        ham[pos] = d[di];
        di++;
      end
    end
    exp_par = '0;
    for (int i = 0; i < m; i++) begin
      p = 1'b0;
      for (int pos = 1; pos <= k + m; pos++)
        if (((pos >> i) & 1) == 1) p = p ^ ham[pos];
      ham[1 << i] = p;
      exp_par[i]  = p;
    end
    exp_ov   = ^ham;
    exp_code = '0;
    for (int pos = 1; pos <= k + m; pos++) begin
      if (lsb) exp_code[pos] = ham[pos];
      else     exp_code[pos-1] = ham[pos];
    end
    if (lsb) exp_code[0] = exp_ov;
    else     exp_code[k+m] = exp_ov;
    check(code == exp_code, lsb ? "R6 R2 R3 code word" : "R5 R2 R3 code word",
          code, exp_code);
    check(^code == 1'b0, "R4 even parity", 72'(^code), 72'(0));
    check(par == exp_par, "R7 parity port", 72'(par), 72'(exp_par));
    check(ov == exp_ov, "R7 overall port", 72'(ov), 72'(exp_ov));
  endtask

  task automatic apply(logic [63:0] v);
    @(negedge clk);
    d8  = v[7:0];
    d16 = v[15:0];
    d32 = v[31:0];
    d64 = v;
    #1; // R9: sampled before any rising edge follows the change
    verify(8,  1'b0, 64'(d8),  72'(c8m), 7'(p8m), o8m);
    verify(8,  1'b1, 64'(d8),  72'(c8l), 7'(p8l), o8l);
    verify(16, 1'b1, 64'(d16), 72'(c16), 7'(p16), o16);
    verify(32, 1'b0, 64'(d32), 72'(c32), 7'(p32), o32);
    verify(64, 1'b0, d64,      c64,      p64,     o64);
  endtask

  initial begin
    logic [63:0] lfsr;
    d8 = '0; d16 = '0; d32 = '0; d64 = '0;
    #2;
    // R8: all-zero data before any clock edge
    check(c8m == '0 && c8l == '0 && c64 == '0, "R8 zero word",
          c64, 72'(0));
    check(p8m == '0 && o8m == 1'b0, "R8 zero parity", 72'({p8m, o8m}), 72'(0));
    // R1: derived widths
    check($bits(u_secded_encoder.code_o) == 13, "R1 width K=8",
          72'($bits(u_secded_encoder.code_o)), 72'(13));
    check($bits(u_secded_encoder_w16.code_o) == 22, "R1 width K=16",
          72'($bits(u_secded_encoder_w16.code_o)), 72'(22));
    check($bits(u_secded_encoder_w32.code_o) == 39, "R1 width K=32",
          72'($bits(u_secded_encoder_w32.code_o)), 72'(39));
    check($bits(u_secded_encoder_w64.code_o) == 72, "R1 width K=64",
          72'($bits(u_secded_encoder_w64.code_o)), 72'(72));
    check($bits(u_secded_encoder_w64.parity_o) == 7, "R1 check bits K=64",
          72'($bits(u_secded_encoder_w64.parity_o)), 72'(7));
    // exhaustive over the 8-bit configurations
    for (int v = 0; v < 256; v++) apply({8{8'(v)}});
    // walking ones over the wide configurations (R2 data order)
    for (int b = 0; b < 64; b++) apply(64'd1 << b);
    apply('1);
    apply(64'h5555_5555_5555_5555);
    apply(64'hAAAA_AAAA_AAAA_AAAA);
    // pseudo-random patterns
    lfsr = 64'hACE1_2468_BDF1_3579;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      apply(lfsr);
    end
    // R9: back to zero with no clock edge in between
    d8 = '0; d64 = '0;
    #1;
    check(c8m == '0 && c64 == '0, "R9 R8 settle to zero", c64, 72'(0));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
      $finish;
    end
  end

endmodule